// File: doc/BRIEF.md
# Quadrature Up/Down Event Counter

This block counts events from two pulse trains that are a quarter period apart. It works out the count direction from which train leads. Both pin inputs pass through an internal synchronizer. Each new synchronized sample is compared with the sample before it, and each valid transition becomes one step up, one step down, or no step.

There are three counting styles:
- **Plain:** counts rising edges of phase B only.
- **Single-edge quadrature:** counts once per input period, on phase-B edges while phase A is high.
- **Four-edge quadrature:** counts on every edge of both phases.

The counter is loaded through a write strobe, and the write goes through a reload register. While the counter is stopped, a write sets both the reload register and the counter. While the counter is running, a write changes only the reload register. The counter picks up the new value at its next wrap.

The count is always visible on an output. A one-cycle pulse marks each wrap. The block produces no pulse output of its own.

Top module: `quad_event_counter`

## Requirements
- R1: After reset the counter reads 0 and the wrap pulse is low.
- R2: A write while `run` is low loads `wr_data` into both the counter and the reload register on the clock edge that samples `wr_en`.
- R3: A write while `run` is high changes only the reload register. The counter keeps counting from its own value and takes the new reload value at its next wrap.
- R4: While `run` is low, input edges do not change the counter. Lowering `run` freezes the count, and the reload register keeps its value.
- R5: With `quad_en` = 0, each rising edge of `phase_b` adds 1. Falling edges of `phase_b` and all edges of `phase_a` have no effect.
- R6: With `quad_en` = 1 and `four_edge` = 0, a rising edge of `phase_b` while `phase_a` is 1 adds 1.
- R7: With `quad_en` = 1 and `four_edge` = 0, a falling edge of `phase_b` while `phase_a` is 1 subtracts 1. Edges of `phase_b` while `phase_a` is 0 and edges of `phase_a` have no effect.
- R8: With `quad_en` = 1 and `four_edge` = 1, the counter adds 1 on every edge of either phase while B lags A. The counting transitions are: A rises with B = 0, B rises with A = 1, A falls with B = 1, and B falls with A = 0.
- R9: With `quad_en` = 1 and `four_edge` = 1, the counter subtracts 1 on each of the four opposite transitions, where B leads A.
- R10: In quadrature modes, a sample in which both phases change at once is illegal and leaves the counter unchanged.
- R11: Counting up from the all-ones value loads the reload register value instead of 0 and raises `wrap` for exactly one cycle.
- R12: Counting down from 0 loads the reload register value and raises `wrap` for exactly one cycle.
- R13: A phase change reaches the counter on the third clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| phase_a | input | 1 | First quadrature phase, asynchronous |
| phase_b | input | 1 | Second quadrature phase, asynchronous |
| quad_en | input | 1 | 1 selects quadrature decoding, 0 selects plain counting of B rising edges |
| four_edge | input | 1 | In quadrature mode, 1 counts all edges and 0 counts once per period |
| run | input | 1 | Counting enable (start bit) |
| wr_en | input | 1 | Write strobe, accepted every cycle |
| wr_data | input | WIDTH | Write value |
| count | output | WIDTH | Current counter value |
| wrap | output | 1 | One-cycle pulse on overflow or underflow reload |

## Verification
The clocked properties assume only that `rst_n` is held for at least one edge. They make no assumption about the phase inputs: any pair of levels, including illegal double changes, must leave the counter stepping by at most one. The wrap properties assume that the pulse follows a step that started from an end value.

The stimulus keeps every phase level stable for four clocks. This lets each change pass through the synchronizer before the next one arrives. Running-mode writes are made while the phases are idle, so a write never coincides with a wrap.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int NBITS  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] d,
  output logic [NBITS-1:0] q
);
  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d[i]};
    end
    assign q[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  a,
  input  logic  b,
  input  logic  quad_en,
  input  logic  four_edge,
  output step_e step
);
  logic a_q, b_q;
  logic a_chg, b_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a;
      b_q <= b;
    end
  end

  assign a_chg = a ^ a_q;
  assign b_chg = b ^ b_q;

  always_comb begin
    step = STEP_NONE;
    if (!quad_en) begin
      if (b && !b_q) step = STEP_UP;
    end else if (a_chg && b_chg) begin
      step = STEP_NONE;
    end else if (four_edge) begin
      if (a_chg)      step = (a != b) ? STEP_UP : STEP_DOWN;
      else if (b_chg) step = (a == b) ? STEP_UP : STEP_DOWN;
    end else begin
      if (b_chg && a) step = b ? STEP_UP : STEP_DOWN;
    end
  end

  a_r5_plain_ignores_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!quad_en && !(b && !b_q)) |-> step == STEP_NONE);
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
  import qdec_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  step_e            step,
  output logic [WIDTH-1:0] count,
  output logic             wrap
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] CNT_MIN = '0;

  logic [WIDTH-1:0] reload_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      reload_q <= '0;
      wrap     <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (wr_en) reload_q <= wr_data;
      if (wr_en && !run) begin
        count <= wr_data;
      end else if (run) begin
        case (step)
          STEP_UP: begin
            if (count == CNT_MAX) begin
              count <= reload_q;
              wrap  <= 1'b1;
            end else begin
              count <= count + 1'b1;
            end
          end
          STEP_DOWN: begin
            if (count == CNT_MIN) begin
              count <= reload_q;
              wrap  <= 1'b1;
            end else begin
              count <= count - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_stopped_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !run) |=> count == $past(wr_data));
  a_r4_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> $stable(count));
  a_r3_running_write_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en && step == STEP_NONE) |=> $stable(count));
  a_r11_up_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step == STEP_UP && count != CNT_MAX) |=> (count == $past(count) + 1'b1) && !wrap);
  a_r12_down_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step == STEP_DOWN && count != CNT_MIN) |=> (count == $past(count) - 1'b1) && !wrap);
  a_r11_wrap_takes_reload: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> count == $past(reload_q));
endmodule

// File: rtl/quad_event_counter.sv
module quad_event_counter
  import qdec_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             quad_en,
  input  logic             four_edge,
  input  logic             run,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] count,
  output logic             wrap
);
  localparam int NPH = 2;

  logic [NPH-1:0] ph_s;
  step_e          step;

  qdec_sync #(.NBITS(NPH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({phase_b, phase_a}),
    .q     (ph_s)
  );

  qdec_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .a         (ph_s[0]),
    .b         (ph_s[1]),
    .quad_en   (quad_en),
    .four_edge (four_edge),
    .step      (step)
  );

  qdec_counter #(.WIDTH(WIDTH)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .step    (step),
    .count   (count),
    .wrap    (wrap)
  );

  a_r10_double_change_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_en && !wr_en && (ph_s[0] != $past(ph_s[0])) && (ph_s[1] != $past(ph_s[1])))
    |=> $stable(count));
endmodule

// File: tb/quad_event_counter_bench.sv
module quad_event_counter_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         phase_a = 1'b0, phase_b = 1'b0;
  logic         quad_en = 1'b0, four_edge = 1'b0, run = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count;
  logic         wrap;

  int checks = 0, errors = 0, wraps_seen = 0;
  logic [W-1:0] m_cnt = '0, m_rel = '0;
  int m_wraps = 0;

  always #4 clk = ~clk;

  quad_event_counter #(.WIDTH(W)) u_quad_event_counter (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .quad_en(quad_en), .four_edge(four_edge), .run(run),
    .wr_en(wr_en), .wr_data(wr_data), .count(count), .wrap(wrap));

  always @(negedge clk) if (rst_n && wrap) wraps_seen++;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int delta(input logic a0, b0, a1, b1);
    logic ac, bc;
    ac = a0 ^ a1; bc = b0 ^ b1;
    if (!quad_en) return (!b0 && b1) ? 1 : 0;
    if (ac && bc) return 0;
    if (four_edge) begin
      if (ac) return (a1 != b1) ? 1 : -1;
      if (bc) return (a1 == b1) ? 1 : -1;
      return 0;
    end
    if (bc && a1) return b1 ? 1 : -1;
    return 0;
  endfunction

  task automatic model_step(input int d);
    if (!run || d == 0) return;
    if (d > 0) begin
      if (m_cnt == '1) begin m_cnt = m_rel; m_wraps++; end
      else m_cnt = m_cnt + 1'b1;
    end else begin
      if (m_cnt == '0) begin m_cnt = m_rel; m_wraps++; end
      else m_cnt = m_cnt - 1'b1;
    end
  endtask

  // R13: the change is sampled by the counter on the third edge; check after the fourth.
  task automatic drive(input logic a, input logic b, input string tag);
    int d;
    d = delta(phase_a, phase_b, a, b);
    model_step(d);
    phase_a = a; phase_b = b;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(tag, count, m_cnt);
  endtask

  task automatic wr(input logic [W-1:0] v);
    wr_en = 1'b1; wr_data = v;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    m_rel = v;
    if (!run) m_cnt = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count", count, 0);
    check("R1 wrap", wrap, 0);

    // R2: stopped write loads counter
    wr(16'h8000);
    check("R2", count, 16'h8000);

    // R13: exact latency of one step
    quad_en = 1'b0; run = 1'b1;
    phase_b = 1'b1; m_cnt = m_cnt + 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R13 not yet", count, 16'h8000);
    @(posedge clk); @(negedge clk);
    check("R13 arrived", count, 16'h8001);
    phase_b = 1'b0;
    repeat (4) @(negedge clk);

    // Exhaustive transition sweep in each decode style
    for (int m = 0; m < 3; m++) begin
      quad_en = (m > 0); four_edge = (m == 2);
      for (int p = 0; p < 4; p++) begin
        for (int n = 0; n < 4; n++) begin
          logic a0, b0, a1, b1;
          int d;
          string tag;
          a0 = p[0]; b0 = p[1]; a1 = n[0]; b1 = n[1];
          drive(a0, b0, "R10 setup");
          d = delta(a0, b0, a1, b1);
          if (quad_en && (a0 != a1) && (b0 != b1)) tag = "R10";
          else if (m == 0) tag = "R5";
          else if (m == 1) tag = (d > 0) ? "R6" : "R7";
          else tag = (d >= 0) ? "R8" : "R9";
          drive(a1, b1, tag);
        end
      end
    end
    check("R12 sweep wraps", wraps_seen, m_wraps);

    // R4: stopping freezes
    quad_en = 1'b1; four_edge = 1'b1;
    drive(1'b0, 1'b0, "R4 idle");
    run = 1'b0;
    drive(1'b1, 1'b0, "R4 frozen");
    drive(1'b1, 1'b1, "R4 frozen");
    drive(1'b0, 1'b1, "R4 frozen");
    drive(1'b0, 1'b0, "R4 frozen");

    // R3 and R11: running write applies at overflow
    wr(16'hFFFE);
    run = 1'b1;
    wr(16'h1234);
    check("R3 count kept", count, 16'hFFFE);
    drive(1'b1, 1'b0, "R11 to max");
    check("R11 max", count, 16'hFFFF);
    drive(1'b1, 1'b1, "R11 wrap");
    check("R11 reload", count, 16'h1234);
    check("R11 one pulse", wraps_seen, m_wraps);

    // R4: reload kept across freeze, R12 underflow
    run = 1'b0;
    wr(16'h0001);
    run = 1'b1;
    wr(16'h00AA);
    run = 1'b0;
    @(negedge clk);
    run = 1'b1;
    drive(1'b1, 1'b0, "R12 down");
    check("R12 zero", count, 0);
    drive(1'b0, 1'b0, "R12 under");
    check("R12 reload", count, 16'h00AA);
    check("R4 reload kept", wraps_seen, m_wraps);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule